// File: doc/BRIEF.md
# Dual-Channel DDR Transmit Sample Interleaver

This block sits between a two-channel baseband sample source and a radio transceiver's transmit data port. In the radio clock domain it takes parallel 12-bit in-phase and quadrature words for two channels. It sends them out on one 12-bit double-data-rate bus, together with a frame marker and a copy of the clock forwarded to the transceiver. Within each clock cycle, the half that begins with the rising edge carries an in-phase word and the half that begins with the falling edge carries the matching quadrature word.

A mode input selects single-channel or two-channel operation. In single-channel mode a new pair leaves the block every cycle. The pair sent is the bitwise OR of both channel inputs, so the source may drive either channel and keep the other at zero. In two-channel mode one sample set takes two cycles. Channel 0 goes out with the frame marker high for the whole cycle, and channel 1 follows with the marker low for the whole cycle. A registered take strobe tells the source at which edges its four words are sampled, so the source holds its words until it sees the strobe.

The output registers and the clock forwarding are modelled behaviourally. The register pair for each half feeds a mux steered by the clock. A target device would map that mux onto its output DDR cells.

Top module: `ddr_tx_interleaver`

## Requirements
- R1: In single-channel mode (dual_mode = 0), an edge at which take_stb is high samples the inputs. During the clock cycle that follows that edge, data_out carries ch0_i | ch1_i while clk is high and ch0_q | ch1_q while clk is low.
- R2: In single-channel mode, frame_out is 1 during the clk-high half and 0 during the clk-low half of every cycle that carries a pair.
- R3: In single-channel mode, take_stb is 1 in every cycle except the first cycle after reset, so a new pair is taken at every rising edge.
- R4: In two-channel mode, an edge that samples the inputs starts a two-cycle slot. In the first cycle data_out carries ch0_i (clk high) then ch0_q (clk low), with frame_out 1 in both halves. In the second cycle it carries ch1_i then ch1_q, with frame_out 0 in both halves.
- R5: In two-channel mode, take_stb toggles every cycle, and the inputs are sampled only at edges where take_stb is high. The channel-1 words sent in the second cycle of a slot are the values present at the sampling edge, even if the inputs change afterwards.
- R6: txclk_out has the frequency of clk and rises when the in-phase half begins, so txclk_out equals clk.
- R7: Reset is synchronous and active high. After an edge at which rst is sampled high, data_out and frame_out are 0 and take_stb is 0. The first cycle after reset is released sends nothing (data_out 0, frame_out 0) and raises take_stb.
- R8: If the mode changes from two-channel to single-channel while the channel-1 cycle of a slot is still pending, that cycle is still sent with frame_out 0. Single-channel sampling starts at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Radio clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 0: single-channel, 1: two-channel |
| ch0_i | input | 12 | Channel 0 in-phase word |
| ch0_q | input | 12 | Channel 0 quadrature word |
| ch1_i | input | 12 | Channel 1 in-phase word |
| ch1_q | input | 12 | Channel 1 quadrature word |
| take_stb | output | 1 | High: the input words are sampled at the coming rising edge |
| txclk_out | output | 1 | Forwarded transmit clock |
| frame_out | output | 1 | Frame marker, DDR |
| data_out | output | 12 | Sample bus, in-phase while clk high, quadrature while clk low |

## Verification
The assertions observe the registered half-cycle words and frame bits. They assume that dual_mode and the channel words change only away from the rising edge, so the value seen at an edge is the one the design samples. In two-channel mode they also assume the source treats take_stb as the only moment its words are taken. The stimulus drives every input 7 ns after a rising edge and reads the bus 2 ns after each edge of the clock, well inside each half. Mode changes happen at the same offset, including one made deliberately while a channel-1 cycle is pending.

// File: rtl/ddr_tx_pkg.sv
package ddr_tx_pkg;

  localparam int NUM_LANES = 2;
  localparam int LANE_I    = 0;
  localparam int LANE_Q    = 1;

  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_SINGLE = 2'd1,
    SLOT_PAIR_A = 2'd2,
    SLOT_PAIR_B = 2'd3
  } slot_e;

  function automatic logic frame_for_rise(slot_e kind);
    return (kind == SLOT_SINGLE) || (kind == SLOT_PAIR_A);
  endfunction

  function automatic logic frame_for_fall(slot_e kind);
    return (kind == SLOT_PAIR_A);
  endfunction

endpackage

// File: rtl/tx_slot_ctrl.sv
module tx_slot_ctrl
  import ddr_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  dual_mode,
  output logic  take_q,
  output slot_e kind
);

  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      take_q <= dual_mode ? ~take_q : 1'b1;
      pend_q <= take_q & dual_mode;
    end
  end

  always_comb begin
    if (take_q) begin
      kind = dual_mode ? SLOT_PAIR_A : SLOT_SINGLE;
    end else if (pend_q) begin
      kind = SLOT_PAIR_B;
    end else begin
      kind = SLOT_IDLE;
    end
  end

endmodule

// File: rtl/tx_ch1_hold.sv
module tx_ch1_hold
  import ddr_tx_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                load,
  input  logic [NUM_LANES-1:0][SAMPLE_W-1:0]  din,
  output logic [NUM_LANES-1:0][SAMPLE_W-1:0]  dout
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (load) begin
      dout <= din;
    end
  end

endmodule

// File: rtl/tx_lane_mux.sv
module tx_lane_mux
  import ddr_tx_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  slot_e                               kind,
  input  logic [NUM_LANES-1:0][SAMPLE_W-1:0]  ch0,
  input  logic [NUM_LANES-1:0][SAMPLE_W-1:0]  ch1,
  input  logic [NUM_LANES-1:0][SAMPLE_W-1:0]  ch1_held,
  output logic [NUM_LANES-1:0][SAMPLE_W-1:0]  lane_out
);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_comb begin
      unique case (kind)
        SLOT_SINGLE: lane_out[g] = ch0[g] | ch1[g];
        SLOT_PAIR_A: lane_out[g] = ch0[g];
        SLOT_PAIR_B: lane_out[g] = ch1_held[g];
        default:     lane_out[g] = '0;
      endcase
    end
  end

endmodule

// File: rtl/tx_ddr_out.sv
module tx_ddr_out
  import ddr_tx_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_LANES-1:0][SAMPLE_W-1:0] lane_in,
  input  slot_e                              kind,
  output logic [SAMPLE_W-1:0]                rise_word_q,
  output logic [SAMPLE_W-1:0]                fall_word_q,
  output logic                               frame_rise_q,
  output logic                               frame_fall_q,
  output logic [SAMPLE_W-1:0]                data_out,
  output logic                               frame_out,
  output logic                               txclk_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_word_q  <= '0;
      fall_word_q  <= '0;
      frame_rise_q <= 1'b0;
      frame_fall_q <= 1'b0;
    end else begin
      rise_word_q  <= lane_in[LANE_I];
      fall_word_q  <= lane_in[LANE_Q];
      frame_rise_q <= frame_for_rise(kind);
      frame_fall_q <= frame_for_fall(kind);
    end
  end

  // Behavioural model of an output DDR cell: the clock steers the half.
  assign data_out  = clk ? rise_word_q : fall_word_q;
  assign frame_out = clk ? frame_rise_q : frame_fall_q;
  assign txclk_out = clk;

endmodule

// File: rtl/ddr_tx_interleaver.sv
module ddr_tx_interleaver
  import ddr_tx_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dual_mode,
  input  logic [SAMPLE_W-1:0] ch0_i,
  input  logic [SAMPLE_W-1:0] ch0_q,
  input  logic [SAMPLE_W-1:0] ch1_i,
  input  logic [SAMPLE_W-1:0] ch1_q,
  output logic                take_stb,
  output logic                txclk_out,
  output logic                frame_out,
  output logic [SAMPLE_W-1:0] data_out
);

  slot_e                               kind;
  logic [NUM_LANES-1:0][SAMPLE_W-1:0]  ch0_v;
  logic [NUM_LANES-1:0][SAMPLE_W-1:0]  ch1_v;
  logic [NUM_LANES-1:0][SAMPLE_W-1:0]  ch1_held;
  logic [NUM_LANES-1:0][SAMPLE_W-1:0]  lane_sel;
  logic [SAMPLE_W-1:0]                 rise_word_r;
  logic [SAMPLE_W-1:0]                 fall_word_r;
  logic                                frame_rise_r;
  logic                                frame_fall_r;

  assign ch0_v[LANE_I] = ch0_i;
  assign ch0_v[LANE_Q] = ch0_q;
  assign ch1_v[LANE_I] = ch1_i;
  assign ch1_v[LANE_Q] = ch1_q;

  tx_slot_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .dual_mode (dual_mode),
    .take_q    (take_stb),
    .kind      (kind)
  );

  tx_ch1_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (kind == SLOT_PAIR_A),
    .din  (ch1_v),
    .dout (ch1_held)
  );

  tx_lane_mux #(.SAMPLE_W(SAMPLE_W)) u_mux (
    .kind     (kind),
    .ch0      (ch0_v),
    .ch1      (ch1_v),
    .ch1_held (ch1_held),
    .lane_out (lane_sel)
  );

  tx_ddr_out #(.SAMPLE_W(SAMPLE_W)) u_out (
    .clk          (clk),
    .rst          (rst),
    .lane_in      (lane_sel),
    .kind         (kind),
    .rise_word_q  (rise_word_r),
    .fall_word_q  (fall_word_r),
    .frame_rise_q (frame_rise_r),
    .frame_fall_q (frame_fall_r),
    .data_out     (data_out),
    .frame_out    (frame_out),
    .txclk_out    (txclk_out)
  );

endmodule

// File: rtl/ddr_tx_interleaver_chk.sv
module ddr_tx_interleaver_chk #(
  parameter int SAMPLE_W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                dual_mode,
  input logic                take_stb,
  input logic [SAMPLE_W-1:0] ch0_i,
  input logic [SAMPLE_W-1:0] ch1_i,
  input logic [SAMPLE_W-1:0] rise_word,
  input logic [SAMPLE_W-1:0] fall_word,
  input logic                frame_rise,
  input logic                frame_fall
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!take_stb && rise_word == '0 && fall_word == '0 && !frame_rise && !frame_fall)); // R7

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dual_mode)) |-> take_stb); // R3

  AST_DUAL_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dual_mode)) |-> (take_stb != $past(take_stb))); // R5

  AST_SINGLE_FRAME: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dual_mode) && $past(take_stb)) |-> (frame_rise && !frame_fall)); // R2

  AST_SINGLE_DATA: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dual_mode) && $past(take_stb)) |-> (rise_word == ($past(ch0_i) | $past(ch1_i)))); // R1

  AST_PAIR_A_FRAME: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dual_mode) && $past(take_stb)) |-> (frame_rise && frame_fall)); // R4

  AST_PAIR_B_HELD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(take_stb) && $past(take_stb, 2) && $past(dual_mode, 2))
      |-> (!frame_rise && !frame_fall && rise_word == $past(ch1_i, 2))); // R5

endmodule

bind ddr_tx_interleaver ddr_tx_interleaver_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .dual_mode  (dual_mode),
  .take_stb   (take_stb),
  .ch0_i      (ch0_i),
  .ch1_i      (ch1_i),
  .rise_word  (rise_word_r),
  .fall_word  (fall_word_r),
  .frame_rise (frame_rise_r),
  .frame_fall (frame_fall_r)
);

// File: tb/ddr_tx_interleaver_tb_top.sv
`timescale 1ns/1ps
module ddr_tx_interleaver_tb_top;

  localparam int W     = 12;
  localparam int NVEC  = 6;

  // {ch0_i, ch0_q, ch1_i, ch1_q}
  localparam logic [4*W-1:0] VECS [NVEC] = '{
    {12'h123, 12'h456, 12'h000, 12'h000},
    {12'h000, 12'h000, 12'hABC, 12'h0DE},
    {12'hF00, 12'h00F, 12'h0F0, 12'h0F0},
    {12'hFFF, 12'hFFF, 12'h000, 12'h000},
    {12'h001, 12'h800, 12'h800, 12'h001},
    {12'h555, 12'hAAA, 12'h2AA, 12'h555}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dual_mode = 1'b0;
  logic [W-1:0] ch0_i = '0, ch0_q = '0, ch1_i = '0, ch1_q = '0;
  logic         take_stb, txclk_out, frame_out;
  logic [W-1:0] data_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ddr_tx_interleaver #(.SAMPLE_W(W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .dual_mode (dual_mode),
    .ch0_i     (ch0_i),
    .ch0_q     (ch0_q),
    .ch1_i     (ch1_i),
    .ch1_q     (ch1_q),
    .take_stb  (take_stb),
    .txclk_out (txclk_out),
    .frame_out (frame_out),
    .data_out  (data_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] c, input logic [W-1:0] d);
    ch0_i = a; ch0_q = b; ch1_i = c; ch1_q = d;
  endtask

  // Sample the high half (+2 ns) then the low half (+7 ns) of the next cycle.
  task automatic cycle_check(input string req, input int exp_i, input int exp_q,
                             input int exp_fr, input int exp_ff, input int exp_stb);
    @(posedge clk);
    #2;
    check({req, " data high half"}, int'(data_out), exp_i);
    check({req, " frame high half"}, int'(frame_out), exp_fr);
    check({req, " take_stb"}, int'(take_stb), exp_stb);
    #5;
    check({req, " data low half"}, int'(data_out), exp_q);
    check({req, " frame low half"}, int'(frame_out), exp_ff);
  endtask

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    // R7: state during reset
    repeat (3) @(posedge clk);
    #2;
    check("R7 reset data", int'(data_out), 0);
    check("R7 reset frame", int'(frame_out), 0);
    check("R7 reset stb", int'(take_stb), 0);
    check("R6 txclk high", int'(txclk_out), 1);
    #5;
    check("R7 reset data low", int'(data_out), 0);
    check("R6 txclk low", int'(txclk_out), 0);
    rst = 1'b0;
    // R7: first cycle after release is idle, strobe rises
    cycle_check("R7 idle", 0, 0, 0, 0, 1);

    // R1 R2 R3: single-channel table
    for (int k = 0; k < NVEC; k++) begin
      logic [W-1:0] a, b, c, d;
      {a, b, c, d} = VECS[k];
      drive(a, b, c, d);
      cycle_check("R1 R2 R3 single", int'(a | c), int'(b | d), 1, 0, 1);
    end

    // R4 R5: two-channel slots, inputs changed while strobe is low
    dual_mode = 1'b1;
    drive(12'h111, 12'h222, 12'h333, 12'h444);
    cycle_check("R4 R5 pair A", 'h111, 'h222, 1, 1, 0);
    drive(12'h555, 12'h666, 12'h777, 12'h888);
    cycle_check("R4 R5 pair B held", 'h333, 'h444, 0, 0, 1);
    cycle_check("R4 R5 pair A second", 'h555, 'h666, 1, 1, 0);
    drive(12'h09A, 12'h09B, 12'h09C, 12'h09D);
    cycle_check("R4 R5 pair B second", 'h777, 'h888, 0, 0, 1);
    cycle_check("R4 pair A third", 'h09A, 'h09B, 1, 1, 0);

    // R8: leave two-channel mode while channel 1 is pending
    dual_mode = 1'b0;
    drive(12'h010, 12'h020, 12'h000, 12'h000);
    cycle_check("R8 pending pair B", 'h09C, 'h09D, 0, 0, 1);
    cycle_check("R8 single resumes", 'h010, 'h020, 1, 0, 1);
    check("R6 txclk low", int'(txclk_out), 0);

    // R7: reset in the middle of traffic
    rst = 1'b1;
    cycle_check("R7 mid reset", 0, 0, 0, 0, 0);
    rst = 1'b0;
    drive(12'h0AA, 12'h055, 12'h000, 12'h000);
    cycle_check("R7 idle after reset", 0, 0, 0, 0, 1);
    cycle_check("R1 after reset", 'h0AA, 'h055, 1, 0, 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule